// File: doc/BRIEF.md
# Multi-Channel Prescaled PWM Generator

This block holds a set of independent pulse-width modulated outputs that all run from one system clock. Each channel divides the clock into time quanta whose length comes from a 4-bit frequency code: one quantum lasts (32 − F) clock cycles. A period is always 1024 quanta long. At the start of each period the output goes high. It stays high for (D + 1) quanta and is low for the rest of the period. D is a 10-bit duty code, so the shortest high time is one quantum, and D = 1023 keeps the output high without a break.

Software configures the block through a byte-wide, write-only register port. Each channel has two configuration bytes. A shared enable register turns channels on and off, with one bit per channel. A disabled channel drives its output low, and this is the only way to get 0 % duty.

Configuration writes land in shadow registers. A running channel picks up new values only at the boundary between two periods, so no period is cut short or mixed from two settings. When a channel is enabled, its counters start from zero and it uses whatever its shadow registers hold at that moment.

Top module: `pwm_multi`

## Requirements
- R1: While `rst` is high, every channel is disabled, every configuration value is cleared and every bit of `pwm_o` is 0.
- R2: A channel whose enable bit is 0 drives its output low. Clearing the bit of a running channel forces the output low in the first cycle after the write edge.
- R3: The enable register is at address 0x48, and bit i controls channel i. Setting the bit of a disabled channel starts a fresh period, with the output high in the first cycle after the write edge.
- R4: The output stays high for exactly (D + 1) × (32 − F) cycles of each period. D is formed as {second byte[1:0], first byte[7:0]}.
- R5: Consecutive rising edges of an enabled channel are exactly 1024 × (32 − F) cycles apart. F is bits [7:4] of the second byte.
- R6: With D = 1023 an enabled output stays high for as long as the channel is enabled, including across period boundaries.
- R7: A configuration write to a running channel changes nothing in the current period. The new values apply from the next period start onward.
- R8: Writes to any address other than the channel bytes and the enable register change neither the outputs nor the enable state.
- R9: Bits [3:2] of a channel's second byte are reserved, and their value has no effect on the waveform.
- R10: Channel i has its first byte at address 0x40 + 2i and its second byte at 0x41 + 2i. Each channel keeps its own timing, independent of the others.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, sampled on the rising clock edge |
| wr_addr | input | 8 | Register address of the write |
| wr_data | input | 8 | Write data byte |
| pwm_o | output | NUM_CH | One modulated output per channel |

## Verification
An enable or disable write changes the affected output in the first cycle after the edge that samples the write. From there, every later edge of the waveform falls at a fixed offset: (D + 1)(32 − F) cycles after the period start for a fall, and 1024(32 − F) cycles for the next rise. The bench reads its own cycle counter just before each write, turns the requirement formulas into absolute cycle numbers for every expected edge, and queues those edges per channel. A monitor samples the outputs on the falling clock edge, matches every observed transition against the head of its channel's queue, and treats any transition it was not told to expect as a failure. Ignored writes and constant-high outputs are therefore checked across whole periods, and not only at single sample points.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    // Field widths of the channel configuration
    localparam int DUTY_W = 10;
    localparam int FREQ_W = 4;
    localparam int PRE_W  = 5;

    // Bit positions inside the second configuration byte
    localparam int HI_DUTY_LSB = 0;
    localparam int FREQ_LSB    = 4;

    typedef logic [DUTY_W-1:0] duty_t;
    typedef logic [FREQ_W-1:0] freq_t;
    typedef logic [PRE_W-1:0]  pre_t;

    typedef struct packed {
        duty_t duty;
        freq_t freq;
    } ch_cfg_t;

    // Final prescaler count for a frequency code: a quantum is 32 - f cycles
    function automatic pre_t last_count(freq_t f);
        return pre_t'(31) - pre_t'(f);
    endfunction

endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
    import pwm_pkg::*;
#(
    parameter int                NUM_CH  = 4,
    parameter int                ADDR_W  = 8,
    parameter logic [ADDR_W-1:0] CH_BASE = 8'h40,
    parameter logic [ADDR_W-1:0] EN_ADDR = 8'h48
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      wr_addr,
    input  logic [7:0]             wr_data,
    output ch_cfg_t [NUM_CH-1:0]   shadow_o,
    output logic [NUM_CH-1:0]      en_o
);

    logic [NUM_CH-1:0] en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= '0;
        end else if (wr_en && (wr_addr == EN_ADDR)) begin
            en_q <= wr_data[NUM_CH-1:0];
        end
    end

    assign en_o = en_q;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_cfg
        localparam logic [ADDR_W-1:0] LO_ADDR = CH_BASE + ADDR_W'(2 * g);
        localparam logic [ADDR_W-1:0] HI_ADDR = CH_BASE + ADDR_W'(2 * g + 1);

        ch_cfg_t cfg_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                cfg_q <= '0;
            end else if (wr_en) begin
                if (wr_addr == LO_ADDR) begin
                    cfg_q.duty[7:0] <= wr_data;
                end else if (wr_addr == HI_ADDR) begin
                    cfg_q.duty[DUTY_W-1:8] <= wr_data[HI_DUTY_LSB +: 2];
                    cfg_q.freq             <= wr_data[FREQ_LSB +: FREQ_W];
                end
            end
        end

        assign shadow_o[g] = cfg_q;
    end

endmodule

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
    import pwm_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  run_i,
    input  freq_t freq_i,
    output logic  tick_o
);

    pre_t cnt_q;
    pre_t last;

    assign last   = last_count(freq_i);
    assign tick_o = run_i && (cnt_q == last);

    always_ff @(posedge clk) begin
        if (rst || !run_i) begin
            cnt_q <= '0;
        end else if (tick_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + pre_t'(1);
        end
    end

endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
    import pwm_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    en_i,
    input  ch_cfg_t shadow_i,
    output logic    pwm_o,
    output logic    tick_o,
    output logic    wrap_o
);

    ch_cfg_t act_q;
    duty_t   quanta_q;
    logic    tick;

    pwm_prescaler u_pre (
        .clk    (clk),
        .rst    (rst),
        .run_i  (en_i),
        .freq_i (act_q.freq),
        .tick_o (tick)
    );

    assign wrap_o = tick && (quanta_q == '1);
    assign tick_o = tick;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q    <= '0;
            quanta_q <= '0;
        end else if (!en_i) begin
            act_q    <= shadow_i;
            quanta_q <= '0;
        end else begin
            if (tick) begin
                quanta_q <= quanta_q + duty_t'(1);
            end
            if (wrap_o) begin
                act_q <= shadow_i;
            end
        end
    end

    assign pwm_o = en_i && (quanta_q <= act_q.duty);

endmodule

// File: rtl/pwm_multi.sv
module pwm_multi
    import pwm_pkg::*;
#(
    parameter int                NUM_CH  = 4,
    parameter int                ADDR_W  = 8,
    parameter logic [ADDR_W-1:0] CH_BASE = 8'h40,
    parameter logic [ADDR_W-1:0] EN_ADDR = 8'h48
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    output logic [NUM_CH-1:0] pwm_o
);

    ch_cfg_t [NUM_CH-1:0] shadow;
    logic    [NUM_CH-1:0] en_vec;
    logic    [NUM_CH-1:0] tick_vec;
    logic    [NUM_CH-1:0] wrap_vec;

    pwm_regs #(
        .NUM_CH  (NUM_CH),
        .ADDR_W  (ADDR_W),
        .CH_BASE (CH_BASE),
        .EN_ADDR (EN_ADDR)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .shadow_o (shadow),
        .en_o     (en_vec)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        pwm_channel u_ch (
            .clk      (clk),
            .rst      (rst),
            .en_i     (en_vec[g]),
            .shadow_i (shadow[g]),
            .pwm_o    (pwm_o[g]),
            .tick_o   (tick_vec[g]),
            .wrap_o   (wrap_vec[g])
        );
    end

endmodule

// File: rtl/pwm_multi_chk.sv
module pwm_multi_chk #(
    parameter int                NUM_CH  = 4,
    parameter int                ADDR_W  = 8,
    parameter logic [ADDR_W-1:0] EN_ADDR = 8'h48
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [NUM_CH-1:0] en_data,
    input logic [NUM_CH-1:0] pwm_o,
    input logic [NUM_CH-1:0] en_vec,
    input logic [NUM_CH-1:0] tick_vec,
    input logic [NUM_CH-1:0] wrap_vec
);

    // R2: a disabled channel never drives high
    p_off_low_r2: assert property (@(posedge clk) disable iff (rst)
        ((pwm_o & ~en_vec) == '0));

    // R2: the prescaler of a disabled channel stays idle
    p_tick_gated_r2: assert property (@(posedge clk) disable iff (rst)
        ((tick_vec & ~en_vec) == '0));

    // R3: a newly enabled channel starts its period high
    p_start_high_r3: assert property (@(posedge clk) disable iff (rst)
        ((en_vec & ~$past(en_vec) & ~pwm_o) == '0));

    // R3: a write to the enable register is taken over as written
    p_enable_load_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (wr_addr == EN_ADDR)) |=> (en_vec == $past(en_data)));

    // R8: any other address leaves the enable state alone
    p_enable_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (wr_addr != EN_ADDR)) |=> $stable(en_vec));

    // R5: a period boundary only happens on a quantum tick
    p_wrap_on_tick_r5: assert property (@(posedge clk) disable iff (rst)
        ((wrap_vec & ~tick_vec) == '0));

endmodule

bind pwm_multi pwm_multi_chk #(
    .NUM_CH  (NUM_CH),
    .ADDR_W  (ADDR_W),
    .EN_ADDR (EN_ADDR)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .en_data  (wr_data[NUM_CH-1:0]),
    .pwm_o    (pwm_o),
    .en_vec   (en_vec),
    .tick_vec (tick_vec),
    .wrap_vec (wrap_vec)
);

// File: tb/pwm_multi_bench.sv
module pwm_multi_bench;

    localparam int         NCH   = 4;
    localparam logic [7:0] BASE  = 8'h40;
    localparam logic [7:0] ENA   = 8'h48;
    localparam int unsigned LIMIT = 150000;

    logic           clk     = 1'b0;
    logic           rst     = 1'b1;
    logic           wr_en   = 1'b0;
    logic [7:0]     wr_addr = '0;
    logic [7:0]     wr_data = '0;
    logic [NCH-1:0] pwm;

    pwm_multi u_pwm_multi (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .pwm_o   (pwm)
    );

    always #10 clk = ~clk;

    int unsigned cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // Scoreboard: per-channel queues of expected edges
    int unsigned atq  [NCH][$];
    bit          lvlq [NCH][$];
    string       reqq [NCH][$];

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    logic [NCH-1:0] last_seen = '0;

    task automatic expect_edge(int c, int unsigned at, bit lvl, string rq);
        atq[c].push_back(at);
        lvlq[c].push_back(lvl);
        reqq[c].push_back(rq);
    endtask

    // Called on a falling edge; the write is taken at the next rising edge
    task automatic wr(logic [7:0] a, logic [7:0] d);
        wr_addr = a;
        wr_data = d;
        wr_en   = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic wait_to(int unsigned c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic check_out(logic [NCH-1:0] exp, string rq);
        checks++;
        if (pwm !== exp) begin
            errors++;
            $display("FAIL %s: pwm_o=%b at cycle %0d, expected %b", rq, pwm, cyc, exp);
        end
    endtask

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    // Monitor: compares every observed transition with the queued edges
    always @(negedge clk) begin
        int unsigned at;
        bit          lv;
        string       rq;
        if (!rst) begin
            for (int c = 0; c < NCH; c++) begin
                if (pwm[c] !== last_seen[c]) begin
                    last_seen[c] = pwm[c];
                    checks++;
                    if (atq[c].size() == 0) begin
                        errors++;
                        $display("FAIL R8 ch%0d: edge to %0b at cycle %0d, expected no edge",
                                 c, pwm[c], cyc);
                    end else begin
                        at = atq[c].pop_front();
                        lv = lvlq[c].pop_front();
                        rq = reqq[c].pop_front();
                        if (at != cyc || lv != pwm[c]) begin
                            errors++;
                            $display("FAIL %s ch%0d: edge to %0b at cycle %0d, expected edge to %0b at cycle %0d",
                                     rq, c, pwm[c], cyc, lv, at);
                        end
                    end
                end
            end
        end
    end

    // Watchdog
    initial begin
        while (cyc < LIMIT && !done) @(negedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: cycle %0d reached, expected completion before %0d", cyc, LIMIT);
            report();
            $finish;
        end
    end

    initial begin
        int unsigned t;

        // R1: reset state
        repeat (3) @(negedge clk);
        check_out('0, "R1");
        rst = 1'b0;
        @(negedge clk);
        check_out('0, "R1");

        // Channel 0: D=9, F=15 (quantum 17 cycles); reserved bits set (R9)
        wr(BASE + 8'd0, 8'd9);
        wr(BASE + 8'd1, 8'hFC);
        t = cyc + 1;
        expect_edge(0, t,                 1'b1, "R3");
        expect_edge(0, t + 170,           1'b0, "R4");
        expect_edge(0, t + 17408,         1'b1, "R5");
        expect_edge(0, t + 17408 + 1700,  1'b0, "R7");
        expect_edge(0, t + 34816,         1'b1, "R5");
        wr(ENA, 8'h01);
        // R7: duty change during the high phase of period one
        wait_to(t + 50);
        wr(BASE + 8'd0, 8'd99);
        check_out(4'b0001, "R7");
        // R2: disable during the high phase of period three
        wait_to(t + 34816 + 499);
        expect_edge(0, cyc + 1, 1'b0, "R2");
        wr(ENA, 8'h00);

        // Channel 1: D=1023, F=0; channel 2: D=0, F=8 (quantum 24 cycles)
        wr(BASE + 8'd2, 8'hFF);
        wr(BASE + 8'd3, 8'h03);
        wr(BASE + 8'd4, 8'h00);
        wr(BASE + 8'd5, 8'h80);
        t = cyc + 1;
        expect_edge(1, t,              1'b1, "R6");
        expect_edge(2, t,              1'b1, "R10");
        expect_edge(2, t + 24,         1'b0, "R4");
        expect_edge(2, t + 24576,      1'b1, "R5");
        expect_edge(2, t + 24576 + 24, 1'b0, "R10");
        wr(ENA, 8'h06);
        // R6: still high after a full period of channel 1 (32768 cycles)
        wait_to(t + 32768 + 100);
        check_out(4'b0010, "R6");
        expect_edge(1, cyc + 1, 1'b0, "R2");
        wr(ENA, 8'h00);

        // R8: unmapped writes with all ones
        wr(ENA + 8'd1, 8'hFF);
        wr(BASE - 8'd1, 8'hFF);
        wr(8'h00, 8'hFF);
        repeat (40) @(negedge clk);
        check_out('0, "R8");

        // Channel 3 at its own offset (R10): D=1, F=15 -> 34 cycles high
        wr(BASE + 8'd6, 8'd1);
        wr(BASE + 8'd7, 8'hF0);
        t = cyc + 1;
        expect_edge(3, t,      1'b1, "R10");
        expect_edge(3, t + 34, 1'b0, "R4");
        wr(ENA, 8'h08);
        // R8: unmapped write of zeros while high must not stop the channel
        wait_to(t + 5);
        wr(8'h49, 8'h00);
        check_out(4'b1000, "R8");
        wait_to(t + 200);

        // Every queued edge must have been seen
        for (int c = 0; c < NCH; c++) begin
            checks++;
            if (atq[c].size() != 0) begin
                errors++;
                $display("FAIL R4 ch%0d: %0d expected edges not seen, expected 0",
                         c, atq[c].size());
            end
        end

        done = 1'b1;
        report();
        $finish;
    end

endmodule